// File: doc/BRIEF.md
# Four-Channel Window Comparator with Interrupt Flags

This block watches the sample words coming out of four independent filter channels and compares each one against its own programmable lower and upper bound. Each channel has two comparators. One catches a sample at or under the lower bound and the other catches a sample at or over the upper bound. The result of each comparison is taken only on a cycle where that channel presents a valid sample, and it is held until the next valid sample of the same channel.

Each of the eight comparison results has its own enable. A disabled result reads as zero. The eight gated results are packed into one status byte, and a single interrupt line is raised whenever any bit of that byte is set. Bounds and enables are plain register inputs driven by the surrounding logic. The filters that produce the samples and any host bus decoding sit outside this block.

Top module: `window_irq_top`

## Requirements
- R1: After reset, every stored comparison result is zero, so `flags` is 8'h00 and `irq` is 0.
- R2: On a cycle with `smp_vld[k]` high, the channel-k lower result becomes 1 when the sample is less than or equal to `lo_lim` of that channel, and 0 otherwise. The result is visible on `flags` one clock later.
- R3: On a cycle with `smp_vld[k]` high, the channel-k upper result becomes 1 when the sample is greater than or equal to `hi_lim` of that channel, and 0 otherwise. The result is visible on `flags` one clock later.
- R4: While `smp_vld[k]` is low, both results of channel k keep their values, whatever the sample and bound inputs do.
- R5: A flag bit whose enable (`lo_en[k]` or `hi_en[k]`) is low reads as 0 in the same cycle. When the enable goes high again, the bit shows the stored result without a new sample.
- R6: Channel k (0-based) drives `flags[2k+1]` with its lower result and `flags[2k]` with its upper result, so bit 7 is the lower result of channel 3 and bit 0 is the upper result of channel 0.
- R7: `irq` is 1 exactly when at least one bit of `flags` is 1.
- R8: Samples and bounds are 16-bit two's complement values and are compared as signed numbers.
- R9: A valid sample on one channel leaves the results of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_data | input | 64 | Four signed samples, channel k in bits [16k+15:16k] |
| smp_vld | input | 4 | Per-channel sample strobe |
| lo_lim | input | 64 | Four signed lower bounds, same packing as the samples |
| hi_lim | input | 64 | Four signed upper bounds, same packing as the samples |
| lo_en | input | 4 | Per-channel enable of the lower flag |
| hi_en | input | 4 | Per-channel enable of the upper flag |
| flags | output | 8 | Packed gated flags, two bits per channel |
| irq | output | 1 | OR of all flag bits |

## Verification
On every cycle the assertions check four things. A stored result never moves without a strobe. A strobe loads exactly the signed inclusive comparison of the previous cycle. A disabled flag reads zero. The interrupt never rises over an empty flag byte. The bench sweeps each channel with samples one below, at and one above both bounds, including the extremes of the signed range and negative bounds, under all four enable pairs. Only these scenarios can show the bit placement in the byte, the independence between channels, and that re-enabling a flag reveals the held result.

// File: rtl/window_irq_pkg.sv
package window_irq_pkg;
    localparam int DEF_CH = 4;
    localparam int DEF_W  = 16;

    typedef struct packed {
        logic below;
        logic above;
    } cmp_state_t;
endpackage

// File: rtl/window_chan.sv
module window_chan
    import window_irq_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] lo_lim,
    input  logic [W-1:0] hi_lim,
    output cmp_state_t   res
);
    cmp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (vld) begin
            state_d.below = ($signed(sample) <= $signed(lo_lim));
            state_d.above = ($signed(sample) >= $signed(hi_lim));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res = state_q;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(res));

    assert_low_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> res.below == ($signed($past(sample)) <= $signed($past(lo_lim))));

    assert_high_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> res.above == ($signed($past(sample)) >= $signed($past(hi_lim))));
endmodule

// File: rtl/window_pack.sv
module window_pack
    import window_irq_pkg::*;
#(
    parameter int NCH = DEF_CH
) (
    input  cmp_state_t [NCH-1:0] res,
    input  logic [NCH-1:0]       lo_en,
    input  logic [NCH-1:0]       hi_en,
    output logic [2*NCH-1:0]     flags,
    output logic                 irq
);
    for (genvar k = 0; k < NCH; k++) begin : g_bits
        assign flags[2*k+1] = res[k].below & lo_en[k];
        assign flags[2*k]   = res[k].above & hi_en[k];
    end

    assign irq = |flags;
endmodule

// File: rtl/window_irq_top.sv
module window_irq_top
    import window_irq_pkg::*;
#(
    parameter int NCH = DEF_CH,
    parameter int W   = DEF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH*W-1:0] smp_data,
    input  logic [NCH-1:0]   smp_vld,
    input  logic [NCH*W-1:0] lo_lim,
    input  logic [NCH*W-1:0] hi_lim,
    input  logic [NCH-1:0]   lo_en,
    input  logic [NCH-1:0]   hi_en,
    output logic [2*NCH-1:0] flags,
    output logic             irq
);
    cmp_state_t [NCH-1:0] res;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        window_chan #(.W(W)) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (smp_vld[k]),
            .sample (smp_data[k*W +: W]),
            .lo_lim (lo_lim[k*W +: W]),
            .hi_lim (hi_lim[k*W +: W]),
            .res    (res[k])
        );

        assert_gate_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !lo_en[k] |-> !flags[2*k+1]);
        assert_gate_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !hi_en[k] |-> !flags[2*k]);
    end

    window_pack #(.NCH(NCH)) i_pack (
        .res   (res),
        .lo_en (lo_en),
        .hi_en (hi_en),
        .flags (flags),
        .irq   (irq)
    );

    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (flags == '0 && !irq));
endmodule

// File: tb/test_window_irq_top.sv
module test_window_irq_top;
    localparam int NCH = 4;
    localparam int W   = 16;

    logic             clk = 0;
    logic             rst_n = 0;
    logic [NCH*W-1:0] smp_data = '0;
    logic [NCH-1:0]   smp_vld = '0;
    logic [NCH*W-1:0] lo_lim = '0;
    logic [NCH*W-1:0] hi_lim = '0;
    logic [NCH-1:0]   lo_en = '0;
    logic [NCH-1:0]   hi_en = '0;
    logic [2*NCH-1:0] flags;
    logic             irq;

    int checks = 0;
    int errors = 0;
    logic m_lo [NCH];
    logic m_hi [NCH];

    always #10 clk = ~clk;

    window_irq_top i_window_irq_top (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_vld(smp_vld),
        .lo_lim(lo_lim), .hi_lim(hi_lim), .lo_en(lo_en), .hi_en(hi_en),
        .flags(flags), .irq(irq)
    );

    function automatic logic [2*NCH-1:0] expect_flags();
        logic [2*NCH-1:0] e;
        for (int k = 0; k < NCH; k++) begin
            e[2*k+1] = m_lo[k] & lo_en[k];
            e[2*k]   = m_hi[k] & hi_en[k];
        end
        return e;
    endfunction

    task automatic check(string tag);
        logic [2*NCH-1:0] e;
        e = expect_flags();
        checks++;
        if (flags !== e) begin
            errors++;
            $display("FAIL %s flags actual %b expected %b", tag, flags, e);
        end
        checks++;
        if (irq !== (e != '0)) begin
            errors++;
            $display("FAIL R7 irq actual %b expected %b", irq, (e != '0));
        end
    endtask

    // one strobe on channel ch, then check one cycle later
    task automatic strobe(int ch, int s, string tag);
        @(negedge clk);
        smp_data[ch*W +: W] = W'(s);
        smp_vld = '0;
        smp_vld[ch] = 1'b1;
        m_lo[ch] = (s <= $signed(lo_lim[ch*W +: W]));
        m_hi[ch] = (s >= $signed(hi_lim[ch*W +: W]));
        @(negedge clk);
        smp_vld = '0;
        #1 check(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int los [4] = '{-5, 0, -32768, 100};
        int his [4] = '{5, 0, 32767, -100};
        for (int k = 0; k < NCH; k++) begin m_lo[k] = 0; m_hi[k] = 0; end
        lo_en = '1; hi_en = '1;
        repeat (3) @(negedge clk);
        #1 check("R1");
        rst_n = 1;
        @(negedge clk);
        #1 check("R1");

        // R2 R3 R6 R8 R9: sweep each channel around both bounds, all enable pairs
        for (int ch = 0; ch < NCH; ch++) begin
            for (int p = 0; p < 4; p++) begin
                for (int en = 0; en < 4; en++) begin
                    @(negedge clk);
                    lo_lim[ch*W +: W] = W'(los[p]);
                    hi_lim[ch*W +: W] = W'(his[p]);
                    lo_en[ch] = en[0];
                    hi_en[ch] = en[1];
                    for (int d = -1; d <= 1; d++) begin
                        if (los[p] + d >= -32768 && los[p] + d <= 32767)
                            strobe(ch, los[p] + d, "R2_R6_R8_R9");
                        if (his[p] + d >= -32768 && his[p] + d <= 32767)
                            strobe(ch, his[p] + d, "R3_R6_R8_R9");
                    end
                end
            end
            lo_en[ch] = 1'b1; hi_en[ch] = 1'b1;
        end

        // R4: hold while strobe low
        for (int k = 0; k < NCH; k++) begin
            lo_lim[k*W +: W] = W'(10); hi_lim[k*W +: W] = W'(20);
        end
        strobe(2, 10, "R4");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_data[2*W +: W] = W'(15 + i);
            lo_lim[2*W +: W] = W'(-50);
            hi_lim[2*W +: W] = W'(50);
            @(negedge clk);
            #1 check("R4");
        end

        // R5: disable and re-enable reveals held result without a new sample
        lo_lim[2*W +: W] = W'(10); hi_lim[2*W +: W] = W'(20);
        strobe(2, 25, "R5");
        @(negedge clk); hi_en = '0;
        #1 check("R5");
        @(negedge clk); hi_en = '1;
        #1 check("R5");
        @(negedge clk); lo_en = '0; hi_en = '0;
        #1 check("R5_R7");

        // R6: one channel at a time, exact bit positions
        lo_en = '1; hi_en = '1;
        for (int k = 0; k < NCH; k++) strobe(k, 15, "R6");
        for (int k = 0; k < NCH; k++) begin
            strobe(k, 5, "R6");
            checks++;
            if (flags !== (8'b1 << (2*k+1))) begin
                errors++;
                $display("FAIL R6 flags actual %b expected %b", flags, 8'b1 << (2*k+1));
            end
            strobe(k, 15, "R6");
            strobe(k, 30, "R6");
            checks++;
            if (flags !== (8'b1 << (2*k))) begin
                errors++;
                $display("FAIL R6 flags actual %b expected %b", flags, 8'b1 << (2*k));
            end
            strobe(k, 15, "R6");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule